// File: doc/BRIEF.md
# Configurable Six-Input Macro-Gate Cell

This cell is a logic element for a mixed logic block. It costs less than a six-input lookup table. Six single-bit logic inputs first pass through individually programmable inverters. They then feed four hard-wired wide-input gate functions. A two-bit selector routes one of the four results through a final programmable inverter to the single output. Because of the negation stages, each fixed gate stands for a whole family of functions. Tying an input to a constant turns a gate into a narrower function of the same family.

The whole personality fits in a 9-bit configuration word rather than a 64-entry truth table. The word is loaded serially. While the load enable is high, each clock edge shifts the word one place toward its top bit and takes in the serial input. The bit pushed out of the top appears on a serial output, so several cells can be daisy-chained. While loading, the logic output is forced low. Outside loading, the path from inputs to output is purely combinational. The configuration register is the only clocked state.

Configuration word layout (LSB = bit 0): bits 0..5 invert inputs a..f in that order (`din[0]` is a, `din[5]` is f). Bit 6 inverts the output. Bits 8:7 pick the gate: 00 = G1, 01 = G2, 10 = G3, 11 = G4.

Top module: `mgate_cell`

## Requirements
- R1: With select 00 and no negation, the output is the AND of all six inputs.
- R2: With select 01, the output is a·b'·c' + b·c·f + b·c'·d + b'·c·e of the (possibly negated) inputs.
- R3: With select 10, the output is a·b'·c·d'·e + b·c·e·f + d·e·f of the (possibly negated) inputs.
- R4: With select 11, the output is a·b' + a'·c·d' + b'·c' + e' + f' of the (possibly negated) inputs.
- R5: Configuration bit k (k = 0..5) inverts input `din[k]` before it reaches any gate.
- R6: Configuration bit 6 inverts the selected gate result at the output.
- R7: While `cfg_en` is high, each rising clock edge shifts the word left by one, with `cfg_in` entering bit 0. Nine such edges load a word sent MSB first. `cfg_out` always shows bit 8, so the previous word leaves MSB first.
- R8: While `cfg_en` is high, `dout` is 0.
- R9: An active-low reset clears the word to all zeros, which gives the plain AND6 function.
- R10: While `cfg_en` is low, the word holds and `cfg_in` has no effect on `dout` or `cfg_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Asynchronous active-low reset of the configuration word |
| cfg_en | input | 1 | Shift enable for the configuration chain; also forces dout low |
| cfg_in | input | 1 | Serial configuration data, MSB first |
| cfg_out | output | 1 | Bit 8 of the configuration word, for daisy-chaining |
| din | input | 6 | Logic inputs; bit 0 is a, bit 5 is f |
| dout | output | 1 | Logic output |

## Verification
Shifting and logic evaluation can coincide: during a load, the word seen by the gates changes on every edge while the output must stay low. Meanwhile the old word drains out on `cfg_out`. The bench drives all-ones inputs during every load, which would raise the output under AND6. At each shift it judges both that `dout` is 0 and that `cfg_out` carries the expected bit of the previous word. Every one of the 512 words is then evaluated against an independent model over all 64 input patterns.

// File: rtl/mgc_pkg.sv
package mgc_pkg;
  localparam int NIN      = 6;
  localparam int SEL_W    = 2;
  localparam int NGATE    = 1 << SEL_W;
  localparam int ONEG_BIT = NIN;
  localparam int SEL_LO   = NIN + 1;
  localparam int CFG_W    = NIN + 1 + SEL_W;

  // x[0]=a ... x[5]=f
  function automatic logic g_and6(input logic [NIN-1:0] x);
    return &x;
  endfunction

  function automatic logic g_mix2(input logic [NIN-1:0] x);
    return (x[0] & ~x[1] & ~x[2]) | (x[1] & x[2] & x[5]) |
           (x[1] & ~x[2] & x[3]) | (~x[1] & x[2] & x[4]);
  endfunction

  function automatic logic g_mix3(input logic [NIN-1:0] x);
    return (x[0] & ~x[1] & x[2] & ~x[3] & x[4]) |
           (x[1] & x[2] & x[4] & x[5]) | (x[3] & x[4] & x[5]);
  endfunction

  function automatic logic g_or5(input logic [NIN-1:0] x);
    return (x[0] & ~x[1]) | (~x[0] & x[2] & ~x[3]) |
           (~x[1] & ~x[2]) | ~x[4] | ~x[5];
  endfunction

  function automatic logic [NGATE-1:0] gate_bank(input logic [NIN-1:0] x);
    return {g_or5(x), g_mix3(x), g_mix2(x), g_and6(x)};
  endfunction
endpackage

// File: rtl/mgc_cfg_chain.sv
module mgc_cfg_chain
  import mgc_pkg::*;
#(
  parameter int W = CFG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         sin,
  output logic         sout,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word <= '0;
    else if (shift_en) word <= {word[W-2:0], sin};
  end

  assign sout = word[W-1];
endmodule

// File: rtl/mgc_invert.sv
module mgc_invert #(
  parameter int N = 6
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] neg,
  output logic [N-1:0] y
);
  for (genvar i = 0; i < N; i++) begin : g_inv
    assign y[i] = neg[i] ? ~x[i] : x[i];
  end
endmodule

// File: rtl/mgc_mux4.sv
module mgc_mux4 (
  input  logic [3:0] g,
  input  logic [1:0] sel,
  output logic       y
);
  logic [1:0] stage0;

  for (genvar i = 0; i < 2; i++) begin : g_lvl0
    assign stage0[i] = sel[0] ? g[2*i+1] : g[2*i];
  end

  assign y = sel[1] ? stage0[1] : stage0[0];
endmodule

// File: rtl/mgate_cell.sv
module mgate_cell
  import mgc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_en,
  input  logic           cfg_in,
  output logic           cfg_out,
  input  logic [NIN-1:0] din,
  output logic           dout
);
  logic [CFG_W-1:0] cfg_q;
  logic [NIN-1:0]   in_neg;
  logic [NIN-1:0]   x_pol;
  logic [NGATE-1:0] gate_vec;
  logic [SEL_W-1:0] gate_sel;
  logic             gate_pick;
  logic             out_neg;
  logic             logic_val;

  mgc_cfg_chain #(.W(CFG_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_en),
    .sin      (cfg_in),
    .sout     (cfg_out),
    .word     (cfg_q)
  );

  assign in_neg   = cfg_q[NIN-1:0];
  assign out_neg  = cfg_q[ONEG_BIT];
  assign gate_sel = cfg_q[SEL_LO +: SEL_W];

  mgc_invert #(.N(NIN)) u_inv (
    .x   (din),
    .neg (in_neg),
    .y   (x_pol)
  );

  assign gate_vec = gate_bank(x_pol);

  mgc_mux4 u_mux (
    .g   (gate_vec),
    .sel (gate_sel),
    .y   (gate_pick)
  );

  assign logic_val = gate_pick ^ out_neg;
  assign dout      = cfg_en ? 1'b0 : logic_val;
endmodule

// File: rtl/mgc_chk.sv
module mgc_chk
  import mgc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic             cfg_in,
  input logic             cfg_out,
  input logic [NIN-1:0]   din,
  input logic             dout,
  input logic [CFG_W-1:0] cfg_word
);
  // R8
  load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> !dout);

  // R7
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> cfg_word[0] == $past(cfg_in));

  // R7
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> cfg_word[CFG_W-1:1] == $past(cfg_word[CFG_W-2:0]));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg_word) && $stable(cfg_out));

  // R1
  and6_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && cfg_word == '0) |-> dout == (din == '1));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> cfg_word == '0);
endmodule

bind mgate_cell mgc_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_en   (cfg_en),
  .cfg_in   (cfg_in),
  .cfg_out  (cfg_out),
  .din      (din),
  .dout     (dout),
  .cfg_word (cfg_q)
);

// File: tb/sim_mgate_cell.sv
`timescale 1ns/1ps
module sim_mgate_cell;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_en = 1'b0;
  logic       cfg_in = 1'b0;
  logic       cfg_out;
  logic [5:0] din = '0;
  logic       dout;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [8:0] cur_cfg = '0;

  always #10 clk = ~clk;

  mgate_cell u0 (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(cfg_in),
    .cfg_out(cfg_out), .din(din), .dout(dout)
  );

  // vector: {cfg[8:0], din[5:0], expected}
  localparam logic [15:0] VEC [10] = '{
    16'h007F, 16'h007C, 16'h03F1, 16'h03F2, 16'h207E,
    16'h4003, 16'h8071, 16'h8030, 16'hC07E, 16'hC03F
  };

  function automatic logic ref_out(input logic [8:0] w, input logic [5:0] p);
    logic a, b, c, d, e, f, r;
    a = p[0] != w[0]; b = p[1] != w[1]; c = p[2] != w[2];
    d = p[3] != w[3]; e = p[4] != w[4]; f = p[5] != w[5];
    case (w[8:7])
      2'd0: r = a && b && c && d && e && f;
      2'd1: r = (b ? (c ? f : d) : (c ? e : a));
      2'd2: r = (e && f && (d || (b && c))) || (a && !b && c && !d && e);
      default: r = !(e && f) || (b ? (!a && c && !d) : (a || !c || (!a && c && !d)));
    endcase
    return r != w[6];
  endfunction

  function automatic string gtag(input logic [1:0] s);
    case (s)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cfg=%03h din=%02h actual=%b expected=%b", tag, cur_cfg, din, act, exp);
    end
  endtask

  // loads word MSB first; checks drain of old word (R7) and quiet output (R8)
  task automatic load(input logic [8:0] w, input logic judge);
    din = 6'h3F;
    for (int i = 8; i >= 0; i--) begin
      @(negedge clk);
      cfg_en = 1'b1;
      cfg_in = w[i];
      #1;
      if (judge) begin
        check("R7 cfg_out drain", cfg_out, cur_cfg[i]);
        check("R8 output held low", dout, 1'b0);
      end
    end
    @(negedge clk);
    cfg_en = 1'b0;
    cfg_in = 1'b0;
    cur_cfg = w;
    #1;
    if (judge) check("R7 new msb on cfg_out", cfg_out, w[8]);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state is AND6
    din = 6'h3F; #1; check("R9 reset AND6 high", dout, 1'b1);
    din = 6'h1F; #1; check("R9 reset AND6 low", dout, 1'b0);
    check("R9 reset cfg_out", cfg_out, 1'b0);

    // vector table
    for (int k = 0; k < 10; k++) begin
      if (VEC[k][15:7] != cur_cfg) load(VEC[k][15:7], 1'b0);
      din = VEC[k][6:1];
      #1;
      check({gtag(VEC[k][15:14]), " R5 R6 vector"}, dout, VEC[k][0]);
    end

    // R5: a'b'c' as a 3-input AND with d,e,f tied high
    load(9'h007, 1'b1);
    for (int p = 0; p < 8; p++) begin
      din = {3'b111, p[2:0]};
      #1;
      check("R5 negated AND3", dout, p[2:0] == 3'b000);
    end

    // R10: cfg_in toggling without enable changes nothing
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      cfg_in = ~cfg_in;
    end
    @(negedge clk);
    din = 6'h38; #1;
    check("R10 cfg_in ignored dout", dout, 1'b1);
    check("R10 cfg_in ignored cfg_out", cfg_out, 1'b0);

    // exhaustive: every word, every pattern
    for (int w = 0; w < 512; w++) begin
      load(w[8:0], 1'b1);
      for (int p = 0; p < 64; p++) begin
        din = p[5:0];
        #1;
        check(gtag(w[8:7]), dout, ref_out(w[8:0], p[5:0]));
      end
    end

    // R9: reset mid-use restores AND6
    load(9'h1C5, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    cur_cfg = '0;
    din = 6'h3F; #1; check("R9 reset again AND6", dout, 1'b1);
    check("R9 reset again cfg_out", cfg_out, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    din = 6'h3B; #1; check("R9 after reset AND6 low", dout, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule